// File: doc/BRIEF.md
# Manchester Line Decoder with Edge-Triggered Sampling

This block turns a serial Manchester-coded line into plain data bits and a recovered bit clock. It runs on a local clock that ticks a fixed number of times per bit period (sixteen by default). A zero is carried as a rising transition in the middle of its bit period and a one as a falling transition there, so the level in the first half of each bit is the bit value.

The decoder does not sample at fixed places in the bit. It waits for a mid-bit transition, counts off three quarters of a bit period, and reads the line: that reading lies in the first half of the following bit and is that bit's value. The line is combined by exclusive-or with a stored polarity flag, and the flag takes the value just read. As a result the next mid-bit transition always appears to the edge detector as a rising edge. Any transition that arrives while the delay is counting, such as a bit-boundary transition, is ignored. A lock indication is set on every capture. It drops, and the polarity flag returns to zero, when no qualifying edge arrives within a time-out window after the detector re-arms.

After a reset, or after a time-out, the polarity flag is zero. The decoder therefore locks on the first rising mid-bit edge, so a transmission should open with a zero bit. The first bit reported is the bit that follows that opening zero.

Top module: `manch_rx`

## Requirements
- R1: With a zero sent as a low-to-high transition at mid-bit and a one as high-to-low, each `valid_o` pulse presents on `data_o` the bit that follows the bit whose mid-bit transition triggered the capture. Every bit of a burst that follows an opening zero is reported once and in order, for any pattern of ones and zeros.
- R2: A capture reads the synchronized line SAMPLE_AT local clocks after the triggering edge is detected. With SYNC_STAGES input flops, `valid_o` is high in the cycle that ends SYNC_STAGES+1+SAMPLE_AT rising clock edges after the mid-bit change of `rx_i` (15 with the defaults).
- R3: `valid_o` is a single-cycle pulse, and `data_o` changes only in a cycle where `valid_o` is high.
- R4: `bclk_o` rises one clock after each accepted mid-bit edge and stays high for exactly OVERSAMPLE/2 clock cycles.
- R5: Transitions of the line while the delay counter runs are ignored. Extra short pulses inserted in the second half of a bit do not change the decoded bits, do not change their timing and do not restart `bclk_o`.
- R6: `locked_o` goes high together with each `valid_o` pulse. After the last capture of a burst, with no further edge, `locked_o` is still high TIMEOUT-1 cycles after the `valid_o` cycle and is low TIMEOUT cycles after it.
- R7: The time-out clears the polarity flag. A burst that opens with a zero after a time-out decodes correctly, even when the last captured value before the time-out was a one and the idle line is high.
- R8: While `rst_ni` is low, `data_o`, `valid_o`, `bclk_o` and `locked_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local sampling clock, OVERSAMPLE ticks per bit period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial Manchester line, asynchronous to clk_i |
| data_o | output | 1 | Last decoded bit, held until the next capture |
| valid_o | output | 1 | One-cycle strobe marking a new `data_o` |
| bclk_o | output | 1 | Recovered bit clock, high for half a bit after each mid-bit edge |
| locked_o | output | 1 | High from a capture until the time-out expires |

## Verification
The bench builds the decoder with its defaults: sixteen ticks per bit, capture at tick twelve, a 32-cycle time-out and two synchronizer stages. This fixes the capture latency at fifteen edges after a line transition and the recovered clock width at eight cycles, and the bench checks both exactly. The 32-cycle window is short enough for every burst to end in a real time-out that the bench observes. The following burst opens from a high idle line while the flag holds a one, which exposes a polarity flag that was not cleared. Random glitches of one or two cycles land in the four cycles after the mid-bit point, inside the counting window and well before the sample point, so they test edge rejection without changing the value at the sample instant.

// File: rtl/manch_rx_pkg.sv
package manch_rx_pkg;

   // Events produced by the delay counter in one clock cycle.
   typedef struct packed {
      logic run;    // delay window open, edge detector disarmed
      logic half;   // last cycle of the recovered clock high phase
      logic done;   // sample point reached
   } dly_evt_t;

   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/manch_rx_sync.sv
module manch_rx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) q <= 1'b0;
            else         q <= d_i;
         end
         assign q_o = q;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sr <= '0;
            else         sr <= {sr[STAGES-2:0], d_i};
         end
         assign q_o = sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/manch_rx_delay.sv
module manch_rx_delay
   import manch_rx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16,
   parameter int unsigned SAMPLE_AT  = 12
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     start_i,
   output dly_evt_t evt_o
);

   localparam int unsigned CW   = cnt_bits(OVERSAMPLE);
   localparam int unsigned HALF = OVERSAMPLE / 2;

   logic [CW-1:0] cnt;
   logic          run;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run <= 1'b0;
         cnt <= '0;
      end else if (start_i) begin
         run <= 1'b1;
         cnt <= '0;
      end else if (run) begin
         if (cnt == CW'(SAMPLE_AT - 1)) begin
            run <= 1'b0;
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign evt_o.run  = run;
   assign evt_o.half = run && (cnt == CW'(HALF - 1));
   assign evt_o.done = run && (cnt == CW'(SAMPLE_AT - 1));

endmodule

// File: rtl/manch_rx_watch.sv
module manch_rx_watch #(
   parameter int unsigned TIMEOUT = 32
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic armed_i,
   input  logic kick_i,
   output logic expire_o
);

   localparam int unsigned TW = $clog2(TIMEOUT + 1);

   logic [TW-1:0] idle;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  idle <= '0;
      else if (kick_i)                              idle <= '0;
      else if (armed_i && idle != TW'(TIMEOUT))     idle <= idle + 1'b1;
   end

   assign expire_o = armed_i && !kick_i && (idle == TW'(TIMEOUT - 1));

endmodule

// File: rtl/manch_rx.sv
module manch_rx
   import manch_rx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE  = 16,
   parameter int unsigned SAMPLE_AT   = 12,
   parameter int unsigned TIMEOUT     = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rx_i,
   output logic data_o,
   output logic valid_o,
   output logic bclk_o,
   output logic locked_o
);

   generate
      if (OVERSAMPLE < 4) begin : g_bad_os
         $error("manch_rx: OVERSAMPLE must be at least 4");
      end
      if (SAMPLE_AT <= OVERSAMPLE / 2 || SAMPLE_AT >= OVERSAMPLE) begin : g_bad_at
         $error("manch_rx: SAMPLE_AT must fall in the first half of the next bit");
      end
      if (TIMEOUT <= OVERSAMPLE - SAMPLE_AT) begin : g_bad_to
         $error("manch_rx: TIMEOUT shorter than the re-arm gap");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("manch_rx: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic     line_s;
   logic     line_q;
   logic     pol;
   logic     trig;
   logic     expire;
   dly_evt_t evt;

   manch_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (rx_i),
      .q_o    (line_s)
   );

   // Both samples are folded with the same flag value, so a flag update
   // can never look like a line edge.
   assign trig = !evt.run && !(line_q ^ pol) && (line_s ^ pol);

   manch_rx_delay #(.OVERSAMPLE(OVERSAMPLE), .SAMPLE_AT(SAMPLE_AT)) u_dly (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (trig),
      .evt_o   (evt)
   );

   manch_rx_watch #(.TIMEOUT(TIMEOUT)) u_watch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .armed_i  (!evt.run),
      .kick_i   (trig || evt.done),
      .expire_o (expire)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         line_q   <= 1'b0;
         pol      <= 1'b0;
         data_o   <= 1'b0;
         valid_o  <= 1'b0;
         locked_o <= 1'b0;
      end else begin
         line_q  <= line_s;
         valid_o <= evt.done;
         if (evt.done) begin
            data_o   <= line_s;
            pol      <= line_s;
            locked_o <= 1'b1;
         end else if (expire) begin
            pol      <= 1'b0;
            locked_o <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bclk_o <= 1'b0;
      else if (trig)     bclk_o <= 1'b1;
      else if (evt.half) bclk_o <= 1'b0;
   end

endmodule

// File: rtl/manch_rx_chk.sv
module manch_rx_chk #(
   parameter int unsigned HALF = 8
) (
   input logic clk_i,
   input logic rst_ni,
   input logic valid_i,
   input logic data_i,
   input logic bclk_i,
   input logic locked_i,
   input logic run_i
);

   logic [15:0] hi_len;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     hi_len <= '0;
      else if (bclk_i) hi_len <= hi_len + 1'b1;
      else             hi_len <= '0;
   end

   // R3
   valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> !valid_i);

   // R3
   data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |-> $stable(data_i));

   // R4
   bclk_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(bclk_i) |-> hi_len == 16'(HALF));

   // R5
   no_retrigger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(run_i) && run_i) |-> !$rose(bclk_i));

   // R6
   lock_on_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |-> locked_i);

   // R6
   lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(locked_i) |-> valid_i);

endmodule

bind manch_rx manch_rx_chk #(.HALF(OVERSAMPLE / 2)) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .valid_i  (valid_o),
   .data_i   (data_o),
   .bclk_i   (bclk_o),
   .locked_i (locked_o),
   .run_i    (evt.run)
);

// File: tb/manch_rx_test.sv
`timescale 1ns/1ps
module manch_rx_test;

   localparam int OS    = 16;
   localparam int AT    = 12;
   localparam int TO    = 32;
   localparam int SYNC  = 2;
   localparam int LAT   = SYNC + 1 + AT;
   localparam int HALFB = OS / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx = 1'b0;
   logic data, valid, bclk, locked;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit done_flag = 1'b0;
   bit mon_on = 1'b0;

   logic exp_v [0:63];
   int   exp_c [0:63];
   int   exp_n = 0;
   int   idx = 0;
   int   last_vcyc = 0;
   logic last_data = 1'b0;
   bit   last_valid = 1'b0;
   int   hi_len = 0;

   always #4 clk = ~clk;

   manch_rx #(.OVERSAMPLE(OS), .SAMPLE_AT(AT), .TIMEOUT(TO), .SYNC_STAGES(SYNC)) uut (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .rx_i     (rx),
      .data_o   (data),
      .valid_o  (valid),
      .bclk_o   (bclk),
      .locked_o (locked)
   );

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int exp_valid_cycle(input int mid_cyc);
      return mid_cyc + LAT;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   // Output monitor: decoded stream, strobe shape, recovered clock width.
   always @(negedge clk) begin
      if (mon_on) begin
         if (valid) begin
            if (idx < exp_n) begin
               check(data == exp_v[idx], "R1 decoded bit", int'(data), int'(exp_v[idx]));
               check(cyc == exp_c[idx], "R2 capture latency", cyc, exp_c[idx]);
            end else begin
               check(1'b0, "R1 unexpected strobe", idx, exp_n);
            end
            check(locked == 1'b1, "R6 lock with strobe", int'(locked), 1);
            idx++;
            last_vcyc = cyc;
            if (last_valid) check(1'b0, "R3 strobe longer than one cycle", 2, 1);
         end else if (data !== last_data) begin
            check(1'b0, "R3 data changed without strobe", int'(data), int'(last_data));
         end
         if (bclk) hi_len++;
         else begin
            if (hi_len != 0) check(hi_len == HALFB, "R4 bit clock width", hi_len, HALFB);
            hi_len = 0;
         end
      end
      last_valid = valid;
      last_data  = data;
   end

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Send an opening zero, then nbits random bits (last one forced to zero),
   // then hold the line at the last second-half level.
   task automatic send_burst(input int nbits, input bit glitchy);
      logic b [0:63];
      idx = 0;
      exp_n = 0;
      b[0] = 1'b0;
      for (int i = 1; i <= nbits; i++) b[i] = logic'($urandom % 2);
      b[nbits] = 1'b0;
      for (int i = 0; i <= nbits; i++) begin
         rx = b[i];
         wait_neg(HALFB);
         rx = ~b[i];
         exp_v[i] = (i < nbits) ? b[i+1] : ~b[nbits];
         exp_c[i] = exp_valid_cycle(cyc);
         exp_n = i + 1;
         if (glitchy && ($urandom % 2 == 1)) begin
            int g;
            int l;
            g = 1 + int'($urandom % 4);
            l = 1 + int'($urandom % 2);
            wait_neg(g);
            rx = b[i];
            wait_neg(l);
            rx = ~b[i];
            wait_neg(HALFB - g - l);
         end else begin
            wait_neg(HALFB);
         end
      end
      // line now holds ~b[nbits] = 1; wait for the final capture
      while (idx < exp_n) @(negedge clk);
      check(idx == nbits + 1, "R1 strobe count", idx, nbits + 1);
      wait_neg(TO - 1 - (cyc - last_vcyc));
      check(locked == 1'b1, "R6 lock before time-out", int'(locked), 1);
      wait_neg(1);
      check(locked == 1'b0, "R6 lock after time-out", int'(locked), 0);
      wait_neg(20);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rx = 1'b0;
      wait_neg(3);
      // R8 reset state
      check(data == 1'b0 && valid == 1'b0, "R8 data/strobe in reset", int'({data, valid}), 0);
      check(bclk == 1'b0 && locked == 1'b0, "R8 clock/lock in reset", int'({bclk, locked}), 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      wait_neg(40);
      check(locked == 1'b0 && valid == 1'b0, "R8 idle after reset", int'({locked, valid}), 0);
      // directed: alternating and constant patterns via short bursts
      send_burst(4, 1'b0);
      send_burst(12, 1'b0);
      // R5 glitches inside the delay window; R7 every burst starts from a high idle line
      for (int k = 0; k < 6; k++) send_burst(8 + int'($urandom % 24), 1'b1);
      for (int k = 0; k < 4; k++) send_burst(8 + int'($urandom % 24), 1'b0);
      // R7 the first bursts after time-outs decoded: pol cleared
      check(fails == 0, "R7 resync after time-out", fails, 0);
      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done_flag) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule